// File: doc/BRIEF.md
# Multi-Queue Interrupt Status Controller

This block keeps the event and interrupt status for a set of command/result queue pairs (six by default). Each queue has one 32-bit status word. The word holds eight sticky event flags, which hardware sets with one-cycle pulses and software clears by writing 1 to them. It also holds a live single-scan status bit and four read-only counter and pointer fields that come from outside the block. Each queue also has an enable word. A flag that is set and enabled raises that queue's interrupt request.

The block watches the trigger line of each queue. It reports a trigger overrun when a queue that is already triggered sees another trigger, and only when the queue is in a hardware trigger mode. One combined error interrupt merges the enabled result-overflow, command-underflow and trigger-overrun requests of every queue. Both interrupt outputs are registered.

Software reaches the block through a word-addressed port. The read path is combinational and the write port is 8 bits wide. The top address bit selects the enable bank (1) or the status bank (0). The low bits select the queue, so consecutive queues sit on consecutive words, which are 4-byte offsets.

Top module: `qstat_ctrl`

## Requirements
- R1: After reset every flag reads 0 except the command-fill flag (bit 6), which reads 1. Every enable word reads 0. `irq_q` and `irq_err` are 0.
- R2: A one-cycle pulse on an event input sets the matching flag at the next clock edge, and the flag then stays set. The flag bits are: 0 result overflow, 1 command underflow, 2 trigger overrun, 3 non-coherency, 4 pause, 5 end of queue, 6 command fill, 7 result drain.
- R3: A write to status word q clears each flag whose `wdata` bit is 1. Flags whose `wdata` bit is 0 keep their value.
- R4: When a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R5: `trig_mode` takes two bits per queue: 0 software, 1 rising edge, 2 falling edge, 3 high level. In level mode, every cycle on which `trig_in` is high counts as a trigger. A trigger that arrives while `q_trig` is 1 sets the overrun flag (bit 2). A trigger that arrives while `q_trig` is 0 leaves the flag unchanged.
- R6: In software mode (0), no activity on `trig_in` ever sets the overrun flag.
- R7: `irq_q[q]` is 1 exactly one cycle after any flag of queue q and the matching bit of its enable word are both 1. It is 0 one cycle after no such pair exists.
- R8: `irq_err` is 1 one cycle after any queue has an enabled flag among bits 0, 1 and 2. Enabled flags in bits 3 to 7 do not raise it.
- R9: Status word q reads as follows: bits 7:0 are the flags; bit 8 is `sss[q]`; bits 15:9 are 0; bits 19:16 are `cf_cnt`; bits 23:20 are `tx_ptr`; bits 27:24 are `rf_cnt`; bits 31:28 are `pop_ptr`, each field being queue q's slice. Addresses whose queue index is NQ or greater read 0 in both banks.
- R10: A write to enable word q (address bit 3 set) loads bits 7:0 of that word. A read returns that value in bits 7:0, with 0 in bits 31:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_rfo | input | NQ | Result overflow event pulses |
| ev_cfu | input | NQ | Command underflow event pulses |
| ev_ncf | input | NQ | Non-coherency event pulses |
| ev_pause | input | NQ | Pause event pulses |
| ev_eoq | input | NQ | End-of-queue event pulses |
| ev_cff | input | NQ | Command fill event pulses |
| ev_rfd | input | NQ | Result drain event pulses |
| sss | input | NQ | Single-scan status per queue |
| trig_mode | input | 2*NQ | Trigger mode per queue |
| trig_in | input | NQ | Trigger lines |
| q_trig | input | NQ | Queue currently triggered |
| cf_cnt | input | NQ*CW | Command fill counts |
| tx_ptr | input | NQ*CW | Transfer-next pointers |
| rf_cnt | input | NQ*CW | Result fill counts |
| pop_ptr | input | NQ*CW | Pop-next pointers |
| wr_en | input | 1 | Write strobe |
| addr | input | $clog2(NQ)+1 | Word address: top bit selects the bank, low bits select the queue |
| wdata | input | 8 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_q | output | NQ | Per-queue interrupt requests |
| irq_err | output | 1 | Combined error interrupt |

## Verification
The bench builds the block with its default values, NQ=6 and CW=4. At that size it can reach every flag of every queue, and every pairing of the four trigger modes with both triggered states under a rise, hold and fall pattern on the trigger line. A 3-bit queue index with only six queues in use leaves indices 6 and 7 free in both banks, so the zero reads of unused addresses are exercised.

// File: rtl/qstat_ctrl.sv
module qstat_ctrl #(
  parameter int NQ = 6,
  parameter int CW = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NQ-1:0]             ev_rfo,
  input  logic [NQ-1:0]             ev_cfu,
  input  logic [NQ-1:0]             ev_ncf,
  input  logic [NQ-1:0]             ev_pause,
  input  logic [NQ-1:0]             ev_eoq,
  input  logic [NQ-1:0]             ev_cff,
  input  logic [NQ-1:0]             ev_rfd,
  input  logic [NQ-1:0]             sss,
  input  logic [2*NQ-1:0]           trig_mode,
  input  logic [NQ-1:0]             trig_in,
  input  logic [NQ-1:0]             q_trig,
  input  logic [NQ*CW-1:0]          cf_cnt,
  input  logic [NQ*CW-1:0]          tx_ptr,
  input  logic [NQ*CW-1:0]          rf_cnt,
  input  logic [NQ*CW-1:0]          pop_ptr,
  input  logic                      wr_en,
  input  logic [$clog2(NQ):0]       addr,
  input  logic [7:0]                wdata,
  output logic [31:0]               rdata,
  output logic [NQ-1:0]             irq_q,
  output logic                      irq_err
);
  localparam int NF  = 8;
  localparam int IW  = $clog2(NQ);
  localparam int PAD = 32 - 4*CW - NF - 1;
  localparam logic [NF-1:0] FL_RST = 8'h40;

  logic [NF-1:0] fl [NQ];
  logic [NF-1:0] en [NQ];
  logic [31:0]   stat [NQ];
  logic [NQ-1:0] trig_d, lvl, err;
  logic [NQ*NF-1:0] fl_all;

  wire [IW-1:0] idx  = addr[IW-1:0];
  wire          bank = addr[IW];

  for (genvar q = 0; q < NQ; q++) begin : g_q
    wire [1:0] md   = trig_mode[2*q +: 2];
    wire       rise = trig_in[q] & ~trig_d[q];
    wire       fall = ~trig_in[q] & trig_d[q];
    wire       trg  = (md == 2'd1 && rise) || (md == 2'd2 && fall) || (md == 2'd3 && trig_in[q]);
    wire       sel  = (idx == IW'(q));
    wire [NF-1:0] set = {ev_rfd[q], ev_cff[q], ev_eoq[q], ev_pause[q],
                         ev_ncf[q], trg & q_trig[q], ev_cfu[q], ev_rfo[q]};
    wire [NF-1:0] clr = (wr_en && !bank && sel) ? wdata : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fl[q] <= FL_RST;
        en[q] <= '0;
      end else begin
        fl[q] <= (fl[q] & ~clr) | set;
        if (wr_en && bank && sel) en[q] <= wdata;
      end
    end

    assign lvl[q] = |(fl[q] & en[q]);
    assign err[q] = |(fl[q][2:0] & en[q][2:0]);
    assign fl_all[q*NF +: NF] = fl[q];
    assign stat[q] = {pop_ptr[q*CW +: CW], rf_cnt[q*CW +: CW], tx_ptr[q*CW +: CW],
                      cf_cnt[q*CW +: CW], {PAD{1'b0}}, sss[q], fl[q]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_d  <= '0;
      irq_q   <= '0;
      irq_err <= 1'b0;
    end else begin
      trig_d  <= trig_in;
      irq_q   <= lvl;
      irq_err <= |err;
    end
  end

  always_comb begin
    rdata = '0;
    for (int q = 0; q < NQ; q++)
      if (idx == IW'(q)) rdata = bank ? {{(32-NF){1'b0}}, en[q]} : stat[q];
  end
endmodule

module qstat_chk #(
  parameter int NQ = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NQ-1:0]       ev_rfo,
  input logic [NQ-1:0]       ev_cfu,
  input logic [2*NQ-1:0]     trig_mode,
  input logic                wr_en,
  input logic [$clog2(NQ):0] addr,
  input logic [7:0]          wdata,
  input logic [NQ*8-1:0]     fl_all,
  input logic [NQ-1:0]       irq_q,
  input logic                irq_err,
  input logic [NQ-1:0]       lvl
);
  localparam int IW = $clog2(NQ);

  for (genvar q = 0; q < NQ; q++) begin : g_c
    wire swr = wr_en && !addr[IW] && (addr[IW-1:0] == IW'(q));

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rfo[q] |=> fl_all[q*8]);
    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (swr && wdata[0] && !ev_rfo[q]) |=> !fl_all[q*8]);
    p_w0_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (swr && !wdata[1] && fl_all[q*8+1]) |=> fl_all[q*8+1]);
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (swr && wdata[1] && ev_cfu[q]) |=> fl_all[q*8+1]);
    p_sw_no_tor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_mode[2*q +: 2] == 2'd0 && !fl_all[q*8+2]) |=> !fl_all[q*8+2]);
    p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[q] |=> irq_q[q]);
    p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl[q] |=> !irq_q[q]);
  end

  p_err_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (irq_q != '0));
endmodule

bind qstat_ctrl qstat_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rfo(ev_rfo), .ev_cfu(ev_cfu),
  .trig_mode(trig_mode), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .fl_all(fl_all), .irq_q(irq_q), .irq_err(irq_err), .lvl(lvl)
);

// File: tb/sim_qstat_ctrl.sv
module sim_qstat_ctrl;
  localparam int CLK_P = 10;
  localparam int NQ = 6;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic [NQ-1:0] evb [8];
  logic [NQ-1:0] sss = '0, trig_in = '0, q_trig = '0;
  logic [2*NQ-1:0] trig_mode = '0;
  logic [NQ*CW-1:0] cf_cnt = '0, tx_ptr = '0, rf_cnt = '0, pop_ptr = '0;
  logic wr_en = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [31:0] rdata;
  logic [NQ-1:0] irq_q;
  logic irq_err;

  int nvec = 0, nerr = 0;
  bit done = 0;
  logic [7:0] xf [NQ];
  logic [NQ-1:0] prev = '0;

  always #(CLK_P/2) clk = ~clk;

  qstat_ctrl #(.NQ(NQ), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_rfo(evb[0]), .ev_cfu(evb[1]), .ev_ncf(evb[3]), .ev_pause(evb[4]),
    .ev_eoq(evb[5]), .ev_cff(evb[6]), .ev_rfd(evb[7]),
    .sss(sss), .trig_mode(trig_mode), .trig_in(trig_in), .q_trig(q_trig),
    .cf_cnt(cf_cnt), .tx_ptr(tx_ptr), .rf_cnt(rf_cnt), .pop_ptr(pop_ptr),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_q(irq_q), .irq_err(irq_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat(input int q);
    logic [3:0] c, t, r, p;
    if (q >= NQ) return 32'h0;
    c = 4'(q); t = 4'(q + 3); r = 4'(15 - q); p = 4'(2*q);
    return {p, r, t, c, 7'b0, sss[q], xf[q]};
  endfunction

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk_stat(input int q, input string tag);
    logic [31:0] d;
    rd(4'(q), d);
    chk(d == exp_stat(q), tag, d, exp_stat(q));
  endtask

  task automatic pulse(input int q, input int b);
    evb[b][q] = 1;
    @(negedge clk);
    evb[b][q] = 0;
    xf[q][b] = 1;
  endtask

  task automatic tstep(input int q, input logic v);
    logic [1:0] md;
    logic trg;
    md = trig_mode[2*q +: 2];
    trig_in[q] = v;
    @(negedge clk);
    trg = (md == 2'd1 && v && !prev[q]) || (md == 2'd2 && !v && prev[q]) || (md == 2'd3 && v);
    if (trg && q_trig[q]) xf[q][2] = 1;
    prev[q] = v;
  endtask

  task automatic set_flag(input int q, input int b);
    if (b == 2) begin
      trig_mode[2*q +: 2] = 2'd1; q_trig[q] = 1;
      tstep(q, 1); tstep(q, 0);
      trig_mode[2*q +: 2] = 2'd0; q_trig[q] = 0;
    end else pulse(q, b);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int b = 0; b < 8; b++) evb[b] = '0;
    for (int q = 0; q < NQ; q++) xf[q] = 8'h40;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int q = 0; q < NQ; q++) begin
      rd(4'(q), d);
      chk(d == 32'h40, "R1 status reset", d, 32'h40);
      rd(4'(8 + q), d);
      chk(d == 0, "R1 enable reset", d, 0);
    end
    chk(irq_q == 0 && irq_err == 0, "R1 irq reset", {irq_err, irq_q}, 0);

    // R9: field layout
    sss = 6'b101001;
    for (int q = 0; q < NQ; q++) begin
      cf_cnt[q*CW +: CW] = 4'(q); tx_ptr[q*CW +: CW] = 4'(q + 3);
      rf_cnt[q*CW +: CW] = 4'(15 - q); pop_ptr[q*CW +: CW] = 4'(2*q);
    end
    for (int q = 0; q < NQ; q++) chk_stat(q, "R9 layout");
    for (int q = NQ; q < 8; q++) begin
      rd(4'(q), d); chk(d == 0, "R9 unused status", d, 0);
      rd(4'(8 + q), d); chk(d == 0, "R9 unused enable", d, 0);
    end

    // R3: clear the command-fill flags
    for (int q = 0; q < NQ; q++) begin
      wr(4'(q), 8'h40); xf[q] = 0;
      chk_stat(q, "R3 clear fill");
    end

    // R2, R3: every event flag of every queue
    for (int q = 0; q < NQ; q++)
      for (int b = 0; b < 8; b++) begin
        if (b == 2) continue;
        pulse(q, b);
        chk_stat(q, "R2 event sets");
        @(negedge clk);
        chk_stat(q, "R2 sticky");
        wr(4'(q), ~(8'(1) << b));
        chk_stat(q, "R3 write 0 keeps");
        wr(4'(q), 8'(1) << b); xf[q][b] = 0;
        chk_stat(q, "R3 write 1 clears");
      end

    // R4: set beats clear
    for (int q = 0; q < NQ; q++) begin
      evb[0][q] = 1; evb[1][q] = 1;
      wr(4'(q), 8'h03);
      evb[0][q] = 0; evb[1][q] = 0;
      xf[q][0] = 1; xf[q][1] = 1;
      chk_stat(q, "R4 set wins");
      wr(4'(q), 8'h03); xf[q] = 0;
      chk_stat(q, "R4 later clear");
    end

    // R5, R6: modes x triggered state x rise/hold/fall
    for (int q = 0; q < NQ; q++)
      for (int m = 0; m < 4; m++)
        for (int t = 0; t < 2; t++) begin
          trig_mode[2*q +: 2] = 2'(m); q_trig[q] = t[0];
          tstep(q, 1); chk_stat(q, m == 0 ? "R6 sw rise" : "R5 rise");
          tstep(q, 1); chk_stat(q, m == 0 ? "R6 sw hold" : "R5 hold");
          tstep(q, 0); chk_stat(q, m == 0 ? "R6 sw fall" : "R5 fall");
          tstep(q, 0);
          trig_mode[2*q +: 2] = 2'd0; q_trig[q] = 0;
          wr(4'(q), 8'h04); xf[q] = 0;
          chk_stat(q, "R3 clear overrun");
        end

    // R7, R8, R10: interrupt gating
    for (int q = 0; q < NQ; q++)
      for (int b = 0; b < 8; b++) begin
        set_flag(q, b);
        wr(4'(8 + q), ~(8'(1) << b));
        @(negedge clk);
        chk(irq_q == 0 && irq_err == 0, "R7 other enables", {irq_err, irq_q}, 0);
        wr(4'(8 + q), 8'(1) << b);
        rd(4'(8 + q), d);
        chk(d == (32'(1) << b), "R10 enable readback", d, 32'(1) << b);
        chk(irq_q == 0, "R7 one cycle latency", irq_q, 0);
        @(negedge clk);
        chk(irq_q == (NQ'(1) << q), "R7 irq raised", irq_q, NQ'(1) << q);
        chk(irq_err == (b < 3), "R8 combined", irq_err, (b < 3));
        wr(4'(q), 8'(1) << b); xf[q][b] = 0;
        @(negedge clk);
        chk(irq_q == 0 && irq_err == 0, "R7 irq drops", {irq_err, irq_q}, 0);
        wr(4'(8 + q), 8'h00);
        chk_stat(q, "R3 state after irq");
      end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule